// File: doc/BRIEF.md
# Debug Breakpoint Counter

This block holds a 16-bit counter for a small CPU's on-chip debug unit. One stored value serves three purposes. It can time how many clocks the CPU runs between two halts. It can count down and request a break when it runs out. It can also act as a program-counter breakpoint. While the CPU is halted in debug mode, the debug command logic reuses the same value as a byte counter for register and memory transfers.

The stored value never counts up. Every read returns its bitwise inverse, so the down-counting cycle timer appears to software as an up-counter that starts at zero. Each mode has its own rule for what happens on leaving and re-entering debug mode. A state machine tracks these rules.

The states are ST_OFF (disabled mode, running), ST_HALT (debug mode), ST_CYC_RUN and ST_CYC_SAT (cycle timer counting, and held at its limit), ST_CD_RUN and ST_CD_DONE (countdown active, and already fired), and ST_PC_WATCH (comparing against the program counter). The transitions are as follows:

- debug entry: any state goes to ST_HALT whenever the debug flag is high.
- debug exit: ST_HALT goes to the run state chosen by the mode select.
- saturate: ST_CYC_RUN goes to ST_CYC_SAT at zero.
- resume: ST_CYC_SAT goes back to ST_CYC_RUN when a write makes the value nonzero.
- fire: ST_CD_RUN goes to ST_CD_DONE at zero.
- remap: any run state goes to the run state of a newly selected mode.

Top module: `dbg_brk_counter`

## Requirements
- R1: Outside a write and the debug-exit reload of R3, the stored value never increases from one clock to the next.
- R2: rd_data always equals the bitwise inverse of the stored value, in every mode and state.
- R3: In cycle mode (mode_sel 00), the first clock edge that sees the debug flag low after debug mode loads the stored value with FFFFH, so rd_data reads 0000H.
- R4: In cycle mode outside debug mode, the stored value falls by one per clock. It stops at 0000H (rd_data FFFFH) and never wraps.
- R5: In countdown mode (mode_sel 01), leaving debug mode keeps the stored value. Decrementing starts on the clock after the exit edge. brk_req goes high for one cycle on the clock after the stored value reaches 0000H, and it does not fire again until debug mode is re-entered and left.
- R6: While the debug flag is high, the stored value does not change except through writes and byte strobes. A countdown halted by debug re-entry resumes from its residual value on the next exit.
- R7: In PC-match mode (mode_sel 10), the stored value is neither reset nor decremented while running. brk_req is high in the same cycle as an insn_start strobe whose pc equals the stored value.
- R8: A byte strobe while the debug flag is high lowers the stored value by one, holding at 0000H. A byte strobe outside debug mode is ignored.
- R9: A write loads wr_data into the stored value without inversion. A write wins over any decrement or reload in the same cycle.
- R10: brk_req is never high while the debug flag is high, and a countdown break lasts exactly one cycle.
- R11: In disabled mode (mode_sel 11), the running CPU leaves the stored value untouched and brk_req stays low.
- R12: A synchronous active-high reset clears the stored value to 0000H (rd_data FFFFH) and enters the disabled state with brk_req low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dbg_mode | input | 1 | High while the CPU is halted in debug mode |
| mode_sel | input | 2 | 00 cycle timer, 01 countdown break, 10 PC match, 11 disabled |
| wr_en | input | 1 | Load strobe from the debug command logic |
| wr_data | input | 16 | Value loaded by wr_en, uninverted |
| byte_dec | input | 1 | Byte-transferred strobe, active only in debug mode |
| pc | input | 16 | Program counter of the next instruction |
| insn_start | input | 1 | High for the cycle in which pc addresses an instruction about to execute |
| brk_req | output | 1 | Break request pulse |
| rd_data | output | 16 | Inverted stored value |

## Verification
The cycle timer is tried with a run that is halted part-way, which separates freezing from reloading, and with a write of 2 during the run, which shows the hold at FFFFH against a wrap. The countdown is loaded with 3, with 10 under a mid-run halt, and with 0 under a halt raised just before and just after the firing edge. These cases separate the exact firing cycle, residual keeping and the debug gating of the request. PC-match is driven with a wrong address, the right address without a strobe, and the right address with a strobe. Byte strobes are issued inside and outside debug mode and at zero, and one coincides with a write.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

    typedef enum logic [1:0] {
        MODE_CYC = 2'b00,
        MODE_CD  = 2'b01,
        MODE_PC  = 2'b10,
        MODE_OFF = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_HALT,
        ST_CYC_RUN,
        ST_CYC_SAT,
        ST_CD_RUN,
        ST_CD_DONE,
        ST_PC_WATCH
    } state_e;

    function automatic state_e run_state(input mode_e m);
        state_e s;
        unique case (m)
            MODE_CYC: s = ST_CYC_RUN;
            MODE_CD:  s = ST_CD_RUN;
            MODE_PC:  s = ST_PC_WATCH;
            default:  s = ST_OFF;
        endcase
        return s;
    endfunction

    function automatic mode_e state_mode(input state_e s);
        mode_e m;
        unique case (s)
            ST_CYC_RUN, ST_CYC_SAT: m = MODE_CYC;
            ST_CD_RUN, ST_CD_DONE:  m = MODE_CD;
            ST_PC_WATCH:            m = MODE_PC;
            default:                m = MODE_OFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dbc_fsm.sv
module dbc_fsm
    import dbc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   dbg_mode,
    input  mode_e  mode,
    input  logic   byte_dec,
    input  logic   cnt_zero,
    output state_e state,
    output logic   ld_max,
    output logic   run_dec,
    output logic   byte_dec_en,
    output logic   cd_fire,
    output logic   brk_q
);

    state_e state_q, state_d;
    logic   mode_match;

    assign state      = state_q;
    assign mode_match = (state_mode(state_q) == mode);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            brk_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            brk_q   <= cd_fire;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (dbg_mode) begin
            state_d = ST_HALT;                          // debug entry
        end else begin
            unique case (state_q)
                ST_HALT:     state_d = run_state(mode); // debug exit
                ST_CYC_RUN:  if (!mode_match) state_d = run_state(mode);
                             else if (cnt_zero) state_d = ST_CYC_SAT;
                ST_CYC_SAT:  if (!mode_match) state_d = run_state(mode);
                             else if (!cnt_zero) state_d = ST_CYC_RUN;
                ST_CD_RUN:   if (!mode_match) state_d = run_state(mode);
                             else if (cnt_zero) state_d = ST_CD_DONE;
                ST_CD_DONE:  if (!mode_match) state_d = run_state(mode);
                ST_PC_WATCH: if (!mode_match) state_d = run_state(mode);
                ST_OFF:      if (!mode_match) state_d = run_state(mode);
                default:     state_d = ST_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        ld_max      = 1'b0;
        run_dec     = 1'b0;
        cd_fire     = 1'b0;
        byte_dec_en = dbg_mode && byte_dec && !cnt_zero;
        if (!dbg_mode) begin
            unique case (state_q)
                ST_HALT:    ld_max  = (mode == MODE_CYC);
                ST_CYC_RUN: run_dec = mode_match && !cnt_zero;
                ST_CD_RUN: begin
                    run_dec = mode_match && !cnt_zero;
                    cd_fire = mode_match && cnt_zero;
                end
                default: ;
            endcase
        end
    end

    AST_BRK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        brk_q |=> !brk_q);                                            // R10
    AST_FIRE_NOT_DEBUG: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_q) |-> !$past(dbg_mode));                           // R10
    AST_HALT_ON_DEBUG: assert property (@(posedge clk) disable iff (rst)
        dbg_mode |=> (state_q == ST_HALT));                           // R6

endmodule

// File: rtl/dbc_count.sv
module dbc_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         ld_max,
    input  logic         dec_en,
    output logic [W-1:0] cnt,
    output logic         cnt_zero
);

    localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= '0;
        else if (wr_en)   cnt_q <= wr_data;
        else if (ld_max)  cnt_q <= CNT_MAX;
        else if (dec_en && cnt_q != '0) cnt_q <= cnt_q - CNT_ONE;
    end

    assign cnt      = cnt_q;
    assign cnt_zero = (cnt_q == '0);

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cnt_q == $past(wr_data)));                         // R9
    AST_ONLY_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !ld_max) |=> (cnt_q <= $past(cnt_q)));             // R1
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !wr_en && !ld_max) |=> (cnt_q == '0));        // R4
    AST_EXIT_MAX: assert property (@(posedge clk) disable iff (rst)
        (ld_max && !wr_en) |=> (cnt_q == CNT_MAX));                   // R3

endmodule

// File: rtl/dbc_pc_match.sv
module dbc_pc_match #(
    parameter int W = 16
) (
    input  logic [W-1:0] pc,
    input  logic [W-1:0] cnt,
    input  logic         insn_start,
    input  logic         armed,
    output logic         hit
);

    assign hit = armed && insn_start && (pc == cnt);

endmodule

// File: rtl/dbg_brk_counter.sv
module dbg_brk_counter
    import dbc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dbg_mode,
    input  logic [1:0]       mode_sel,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             byte_dec,
    input  logic [CNT_W-1:0] pc,
    input  logic             insn_start,
    output logic             brk_req,
    output logic [CNT_W-1:0] rd_data
);

    mode_e            mode;
    state_e           state;
    logic             ld_max, run_dec, byte_dec_en, cd_fire, brk_q;
    logic             cnt_zero, pc_hit, pc_armed;
    logic [CNT_W-1:0] cnt;

    assign mode = mode_e'(mode_sel);

    dbc_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .dbg_mode    (dbg_mode),
        .mode        (mode),
        .byte_dec    (byte_dec),
        .cnt_zero    (cnt_zero),
        .state       (state),
        .ld_max      (ld_max),
        .run_dec     (run_dec),
        .byte_dec_en (byte_dec_en),
        .cd_fire     (cd_fire),
        .brk_q       (brk_q)
    );

    dbc_count #(.W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ld_max   (ld_max),
        .dec_en   (run_dec | byte_dec_en),
        .cnt      (cnt),
        .cnt_zero (cnt_zero)
    );

    assign pc_armed = !dbg_mode && (state == ST_PC_WATCH) && (mode == MODE_PC);

    dbc_pc_match #(.W(CNT_W)) u_match (
        .pc         (pc),
        .cnt        (cnt),
        .insn_start (insn_start),
        .armed      (pc_armed),
        .hit        (pc_hit)
    );

    assign brk_req = (brk_q | pc_hit) & ~dbg_mode;
    assign rd_data = ~cnt;

    AST_DEBUG_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (dbg_mode && !wr_en && !byte_dec) |=> $stable(cnt));          // R6
    AST_PC_NO_DEC: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PC_WATCH && !wr_en && !byte_dec) |=> $stable(cnt)); // R7
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OFF) |-> !brk_req);                              // R11

endmodule

// File: tb/sim_dbg_brk_counter.sv
module sim_dbg_brk_counter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dbg = 1'b0;
    logic [1:0]  mode = 2'b11;
    logic        wr = 1'b0;
    logic [15:0] wd = '0;
    logic        bdec = 1'b0;
    logic [15:0] pc = '0;
    logic        istart = 1'b0;
    logic        brk;
    logic [15:0] rd;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_brk_counter u0 (
        .clk(clk), .rst(rst), .dbg_mode(dbg), .mode_sel(mode),
        .wr_en(wr), .wr_data(wd), .byte_dec(bdec), .pc(pc),
        .insn_start(istart), .brk_req(brk), .rd_data(rd)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] v);
        wr = 1'b1; wd = v; step(); wr = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; step(); step(); rst = 1'b0; step();
        chk("R12 read after reset", rd, 16'hFFFF);
        chk("R12 brk after reset", {15'd0, brk}, 16'd0);
    endtask

    task automatic t_cycle();
        dbg = 1'b1; mode = 2'b00; step();
        load(16'h1234);
        chk("R2 inverted read", rd, 16'hEDCB);
        chk("R9 uninverted write", ~rd, 16'h1234);
        dbg = 1'b0; step();
        chk("R3 reload on exit", rd, 16'h0000);
        repeat (5) step();
        chk("R4 counts per clock", rd, 16'h0005);
        dbg = 1'b1; step();
        chk("R6 freeze on entry", rd, 16'h0005);
        step();
        chk("R6 still frozen", rd, 16'h0005);
        dbg = 1'b0; step();
        chk("R3 reload on second exit", rd, 16'h0000);
        load(16'h0002);
        chk("R9 write while running", rd, 16'hFFFD);
        step(); step();
        chk("R4 reaches limit", rd, 16'hFFFF);
        step(); step();
        chk("R4 holds without wrap", rd, 16'hFFFF);
        chk("R4 no break in cycle mode", {15'd0, brk}, 16'd0);
    endtask

    task automatic t_countdown();
        dbg = 1'b1; mode = 2'b01; step();
        load(16'h0003);
        dbg = 1'b0; step();
        chk("R5 kept on exit", rd, 16'hFFFC);
        step(); step(); step();
        chk("R5 reached zero", rd, 16'hFFFF);
        chk("R5 no break at zero edge", {15'd0, brk}, 16'd0);
        step();
        chk("R5 break fires", {15'd0, brk}, 16'd1);
        step();
        chk("R10 break one cycle", {15'd0, brk}, 16'd0);
        repeat (3) step();
        chk("R5 no refire", {15'd0, brk}, 16'd0);
    endtask

    task automatic t_reentry();
        dbg = 1'b1; mode = 2'b01; step();
        load(16'd10);
        dbg = 1'b0; step(); step(); step();
        chk("R5 running down", rd, ~16'd8);
        dbg = 1'b1; step(); step();
        chk("R6 residual held", rd, ~16'd8);
        dbg = 1'b0; step();
        chk("R6 residual kept on exit", rd, ~16'd8);
        step();
        chk("R6 resumes from residual", rd, ~16'd7);
    endtask

    task automatic t_suppress();
        dbg = 1'b1; mode = 2'b01; step();
        load(16'h0000);
        dbg = 1'b0; step();
        dbg = 1'b1; step();
        chk("R10 halted before firing", {15'd0, brk}, 16'd0);
        step();
        chk("R10 still quiet in debug", {15'd0, brk}, 16'd0);
        dbg = 1'b0; step(); step();
        chk("R5 fires from zero", {15'd0, brk}, 16'd1);
        dbg = 1'b1; #1;
        chk("R10 gated by debug", {15'd0, brk}, 16'd0);
        step();
    endtask

    task automatic t_pcmatch();
        dbg = 1'b1; mode = 2'b10; step();
        load(16'h0400);
        dbg = 1'b0; step();
        pc = 16'h0300; istart = 1'b1; #1;
        chk("R7 wrong address", {15'd0, brk}, 16'd0);
        step();
        pc = 16'h0400; istart = 1'b0; #1;
        chk("R7 no strobe", {15'd0, brk}, 16'd0);
        istart = 1'b1; #1;
        chk("R7 match breaks", {15'd0, brk}, 16'd1);
        step();
        istart = 1'b0;
        repeat (4) step();
        chk("R7 not decremented", rd, 16'hFBFF);
        dbg = 1'b1; step();
        dbg = 1'b0; step();
        chk("R7 not reset on resume", rd, 16'hFBFF);
    endtask

    task automatic t_bytes();
        dbg = 1'b1; mode = 2'b11; step();
        load(16'h0002);
        bdec = 1'b1; step();
        chk("R8 byte decrement", rd, ~16'h0001);
        step(); step();
        chk("R8 holds at zero", rd, 16'hFFFF);
        bdec = 1'b0;
        load(16'h0009);
        wr = 1'b1; wd = 16'h0050; bdec = 1'b1; step();
        wr = 1'b0; bdec = 1'b0;
        chk("R9 write beats byte strobe", rd, 16'hFFAF);
        dbg = 1'b0; step();
        load(16'h0005);
        bdec = 1'b1; step(); step(); bdec = 1'b0;
        chk("R8 ignored outside debug", rd, 16'hFFFA);
        repeat (4) step();
        chk("R11 disabled keeps value", rd, 16'hFFFA);
        chk("R11 disabled no break", {15'd0, brk}, 16'd0);
        chk("R1 disabled never rises", ~rd, 16'h0005);
    endtask

    initial begin
        t_reset();
        t_cycle();
        t_countdown();
        t_reentry();
        t_suppress();
        t_pcmatch();
        t_bytes();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule